// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Bank

This block holds one sticky event flag for each of the message buffers of a CAN-style controller. The transmit/receive engine raises a flag with a one-cycle completion pulse for that buffer. Software reads the flags over a simple register bus and clears them by writing ones. A mask register of the same width selects which flags may drive a single interrupt request. The request is a registered output.

An input enables receive-FIFO mode, which changes how the lowest eight flags behave. Bits 7, 6 and 5 then report FIFO conditions instead of buffer completions. Bits 4 to 0 become reserved. The hardware never clears flags by itself when the mode changes. Each flag keeps its stored value until software clears it.

Top module: `mbuf_irq_flags`

## Requirements
- R1: While reset is high at a clock edge, the flags, the mask and the interrupt output all go to zero.
- R2: A completion pulse on buffer i sets flag bit i at the next clock edge. This holds for every bit when FIFO mode is off, and for bits 8 and up when FIFO mode is on.
- R3: A register write with select 0 clears every flag bit whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R4: If a set event and a write-one-to-clear reach the same flag bit in the same cycle, the flag ends up set.
- R5: A register write with select 1 loads the whole data word into the mask. `mask_o` shows the mask value.
- R6: `irq_o` is high in the cycle after the visible flags ANDed with the mask are non-zero, and low in the cycle after that AND is zero.
- R7: In FIFO mode, bit 5 is set by `fifo_avail_i`, bit 6 by `fifo_warn_i` and bit 7 by `fifo_ovf_i`. Completion pulses for buffers 0 to 7 are ignored in this mode.
- R8: In FIFO mode, bits 4 to 0 read as zero and take no part in the interrupt. Set pulses and write-one-to-clear do not change them. Their stored values are kept and become visible again when FIFO mode is switched off.
- R9: When FIFO mode is off, the three FIFO condition pulses have no effect on any flag.
- R10: Switching FIFO mode on or off does not change bits 5 to 7. They stay set until software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_done_i | input | 32 | One-cycle completion pulse, one bit per buffer |
| fifo_en_i | input | 1 | Receive-FIFO mode enable |
| fifo_avail_i | input | 1 | FIFO frames-available pulse (sets bit 5 in FIFO mode) |
| fifo_warn_i | input | 1 | FIFO almost-full pulse (sets bit 6 in FIFO mode) |
| fifo_ovf_i | input | 1 | FIFO overflow pulse (sets bit 7 in FIFO mode) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 for the flags (write one to clear), 1 for the mask |
| wr_data_i | input | 32 | Write data |
| flags_o | output | 32 | Visible flag word (reserved bits forced to zero in FIFO mode) |
| mask_o | output | 32 | Mask register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Directed sequences first separate a buffer set from a write-one-to-clear. They then check a data-zero write against a data-one write, and a set against a clear when both land on the same bit in the same cycle. Next come the FIFO mode cases. Stored reserved bits are checked in both modes, so that a masked read can be told apart from a real clear. The three FIFO pulses are applied in FIFO mode and outside it, so that repurposing can be told apart from a plain OR of sources. A long random run follows. It uses sparse completion pulses, random register writes, and rare FIFO mode toggles. Every cycle the flags, the mask and the interrupt are compared with a bench model. This exposes ordering and priority errors that the directed cases cannot reach.

// File: rtl/mbuf_irq_pkg.sv
package mbuf_irq_pkg;
  localparam int unsigned MB_COUNT_DEF  = 32;
  localparam int unsigned FIFO_SPAN     = 8;
  localparam int unsigned FIFO_EVENTS   = 3;
  localparam int unsigned RSVD_SPAN     = FIFO_SPAN - FIFO_EVENTS;

  typedef enum logic {
    SEL_FLAGS = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mbuf_flag_cell.sv
module mbuf_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b0;
    else if (!hold_i)
      flag_q <= set_i | (flag_q & ~clr_i);
  end

  // R4: a set beats a simultaneous clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i && !hold_i) |=> flag_q);
  // R3: a clear without a set empties the flag
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && !hold_i) |=> !flag_q);
  // R8: a held flag keeps its stored value
  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(flag_q));
endmodule

// File: rtl/mbuf_irq_reduce.sv
module mbuf_irq_reduce #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flags_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_i & mask_i);
  end
endmodule

// File: rtl/mbuf_irq_flags.sv
module mbuf_irq_flags
  import mbuf_irq_pkg::*;
#(
  parameter int unsigned NUM_MB = MB_COUNT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] buf_done_i,
  input  logic              fifo_en_i,
  input  logic              fifo_avail_i,
  input  logic              fifo_warn_i,
  input  logic              fifo_ovf_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [NUM_MB-1:0] wr_data_i,
  output logic [NUM_MB-1:0] flags_o,
  output logic [NUM_MB-1:0] mask_o
  ,
  output logic              irq_o
);
  localparam int unsigned LOW_RSVD = RSVD_SPAN;
  localparam int unsigned LOW_FIFO = FIFO_SPAN;

  logic [NUM_MB-1:0]      flag_q;
  logic [NUM_MB-1:0]      mask_q;
  logic [FIFO_EVENTS-1:0] fifo_src;
  logic                   wr_flags;
  logic                   wr_mask;

  assign fifo_src = {fifo_ovf_i, fifo_warn_i, fifo_avail_i};
  assign wr_flags = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FLAGS);
  assign wr_mask  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
    logic set_b, clr_b, hold_b;
    assign clr_b = wr_flags & wr_data_i[i];
    if (i < LOW_RSVD) begin : g_rsvd
      assign set_b      = buf_done_i[i];
      assign hold_b     = fifo_en_i;
      assign flags_o[i] = flag_q[i] & ~fifo_en_i;
    end else if (i < LOW_FIFO) begin : g_fifo
      assign set_b      = fifo_en_i ? fifo_src[i-LOW_RSVD] : buf_done_i[i];
      assign hold_b     = 1'b0;
      assign flags_o[i] = flag_q[i];
    end else begin : g_plain
      assign set_b      = buf_done_i[i];
      assign hold_b     = 1'b0;
      assign flags_o[i] = flag_q[i];
    end

    mbuf_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_b),
      .clr_i  (clr_b),
      .hold_i (hold_b),
      .flag_q (flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= wr_data_i;
  end
  assign mask_o = mask_q;

  mbuf_irq_reduce #(.WIDTH(NUM_MB)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags_o),
    .mask_i  (mask_q),
    .irq_q   (irq_o)
  );

  // R1: state is empty right after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags_o == '0 && mask_o == '0 && !irq_o));
  // R6: interrupt follows the masked flags one cycle later
  a_r6_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (|(flags_o & mask_o)) |=> irq_o);
  a_r6_irq_drop: assert property (@(posedge clk) disable iff (rst)
    !(|(flags_o & mask_o)) |=> !irq_o);
  // R8: reserved bits read as zero in FIFO mode
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    fifo_en_i |-> (flags_o[LOW_RSVD-1:0] == '0));
  // R5: mask write lands next cycle
  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_o == $past(wr_data_i)));
endmodule

// File: tb/test_mbuf_irq_flags.sv
`timescale 1ns/1ps
module test_mbuf_irq_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] buf_done = '0;
  logic        fifo_en = 1'b0, f_avail = 1'b0, f_warn = 1'b0, f_ovf = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] flags, mask;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] m_flags = '0, m_mask = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  mbuf_irq_flags i_mbuf_irq_flags (
    .clk(clk), .rst(rst), .buf_done_i(buf_done), .fifo_en_i(fifo_en),
    .fifo_avail_i(f_avail), .fifo_warn_i(f_warn), .fifo_ovf_i(f_ovf),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .flags_o(flags), .mask_o(mask), .irq_o(irq)
  );

  function automatic logic [31:0] visible(logic [31:0] f, logic en);
    return en ? (f & ~32'h1F) : f;
  endfunction

  function automatic logic [31:0] next_flags(logic [31:0] f, logic en, logic [31:0] d,
      logic [2:0] src, logic we, logic sel, logic [31:0] wd);
    logic [31:0] r = f;
    for (int i = 0; i < 32; i++) begin
      logic s, c;
      if (en && i < 5) continue;
      s = (en && i >= 5 && i < 8) ? src[i-5] : d[i];
      c = we && !sel && wd[i];
      r[i] = s | (f[i] & ~c);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model updates at the edge, then wait to the next negedge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_flags = '0; m_mask = '0; m_irq = 1'b0;
    end else begin
      m_irq = |(visible(m_flags, fifo_en) & m_mask);
      m_flags = next_flags(m_flags, fifo_en, buf_done, {f_ovf, f_warn, f_avail},
                           wr_en, wr_sel, wr_data);
      if (wr_en && wr_sel) m_mask = wr_data;
    end
    @(negedge clk);
    buf_done = '0; f_avail = 0; f_warn = 0; f_ovf = 0; wr_en = 0;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    buf_done = 32'hFFFF_FFFF; wr(1, 32'hFFFF_FFFF);
    step(); step(); rst = 0; buf_done = '0; wr_en = 0;
    chk("R1 flags", flags, 0); chk("R1 mask", mask, 0); chk("R1 irq", {31'b0, irq}, 0);

    wr(1, 32'hFFFF_FFFF); step();
    chk("R5 mask load", mask, 32'hFFFF_FFFF);
    buf_done = 32'h1000; step();
    chk("R2 set bit12", flags, 32'h1000);
    chk("R6 irq lag", {31'b0, irq}, 0);
    step();
    chk("R6 irq high", {31'b0, irq}, 1);
    wr(0, 32'h0); step();
    chk("R3 zero write", flags, 32'h1000);
    wr(0, 32'h1000); buf_done = 32'h1000; step();
    chk("R4 set wins", flags, 32'h1000);
    wr(0, 32'h1000); step();
    chk("R3 clear", flags, 0);
    step();
    chk("R6 irq low", {31'b0, irq}, 0);

    buf_done = 32'h1F; step();
    chk("R2 low bits", flags, 32'h1F);
    fifo_en = 1; step();
    chk("R8 read zero", flags, 0);
    chk("R8 no irq", {31'b0, irq}, 0);
    wr(0, 32'h1F); buf_done = 32'hFF; step();
    chk("R7 buf pulses ignored", flags, 0);
    f_avail = 1; step(); chk("R7 avail bit5", flags, 32'h20);
    f_warn = 1;  step(); chk("R7 warn bit6", flags, 32'h60);
    f_ovf = 1;   step(); chk("R7 ovf bit7", flags, 32'hE0);
    fifo_en = 0; step();
    chk("R8 R10 kept after mode off", flags, 32'hFF);
    f_avail = 1; f_warn = 1; f_ovf = 1; wr(0, 32'hFF); step();
    chk("R9 fifo pulses ignored", flags, 0);
    chk("R9 model sync", m_flags, 0);

    for (int n = 0; n < 4000; n++) begin
      buf_done = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0;
      if ($urandom_range(0, 7) == 0) buf_done |= $urandom() & $urandom();
      f_avail = ($urandom_range(0, 5) == 0);
      f_warn  = ($urandom_range(0, 7) == 0);
      f_ovf   = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 60) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 5) == 0, $urandom() | $urandom());
      step();
      chk("R2 R3 R4 R7 R8 R10 random flags", flags, visible(m_flags, fifo_en));
      chk("R5 random mask", mask, m_mask);
      chk("R6 random irq", {31'b0, irq}, {31'b0, m_irq});
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));
endmodule